// File: doc/BRIEF.md
# I2C Register-Bank Target

This block is an I2C target that lets a bus host read and write a small bank of 8-bit control registers. Everything runs on the system clock: SCL and SDA are brought in through two-flop synchronisers, START, repeated START and STOP are recognised from the synchronised lines, and SDA is driven only through an open-drain pull-low enable. The block supports neither clock stretching nor 10-bit addressing. The system clock must run at least eight times faster than SCL.

The target answers to the 7-bit address 1011X00. Bit A2 is a don't-care, so the block responds at 0x58 and at 0x5C. A transfer starts with the address in write mode. The byte after it loads an internal register pointer. Each further byte in write mode is stored at the pointer, and the pointer then steps up by one. To read, the host sets the pointer, issues a repeated START, and sends the address again in read mode. The target then returns bytes starting at the pointed register, stepping the pointer after each byte. In both directions the pointer wraps from the last register back to register 0. Every register is visible on a flat parallel bus.

Top module: `i2c_regbank_target`

## Requirements
- R1: The target ACKs an address byte whose upper seven bits are 1011X00 (A6..A0, X = either value). On any other address it drives no ACK and leaves SDA released and the registers untouched until the next START or STOP.
- R2: After a write-mode address, the next byte is ACKed and loaded into the pointer modulo 16. For example, 0x12 selects register 2.
- R3: Each data byte after the pointer byte is ACKed, written to the pointed register, and followed by a pointer increment.
- R4: A register takes its new value at the ACK of its own data byte, before any STOP. During a multi-byte write, a register further along the burst still holds its old value.
- R5: A STOP or a repeated START that arrives partway through a data byte discards the partial bits. No register changes because of them.
- R6: The pointer survives a repeated START. A read-mode address (R/W bit = 1, bit 0 of the address byte) is ACKed, and the pointed register is then returned MSB first.
- R7: During a read, the pointer advances by one after each byte, so consecutive bytes come from consecutive registers while the host keeps ACKing.
- R8: The pointer wraps from register 15 to register 0, both when writing and when reading.
- R9: After the host NACKs a read byte, the target keeps SDA released and sends nothing more until a START or a STOP.
- R10: After reset, all 16 registers read 0x00 and SDA is released.
- R11: The SDA pull-low enable changes only while SCL is low.
- R12: Register i appears on regs_o bits [8i+7:8i].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level from the pad |
| sda_i | input | 1 | SDA line level from the pad |
| sda_oe_o | output | 1 | 1 = pull SDA low, 0 = release |
| regs_o | output | 128 | All 16 registers, register i at bits [8i+7:8i] |

## Verification
The bench runs a burst that starts at register 14. Across that burst it checks register contents after every single ACK. A design that waited for STOP to commit, or that failed to wrap, would show stale registers or write past the bank. It aborts write bytes both with a STOP and with a repeated START, to catch a design that commits half-received bytes. It also reads back through a repeated START, which exposes a pointer that is cleared on START. After a host NACK, it clocks extra SCL pulses, so a target that keeps shifting out data would be seen pulling SDA low. A mismatched address is followed by ordinary bytes, which a target that ignores the A1/A0 bits would wrongly ACK and store.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_WDATA,
    ST_ACK,
    ST_RDATA,
    ST_RACK,
    ST_SKIP
  } bus_state_t;

  // True when the received 7-bit address equals the base in every bit not masked as don't-care
  function automatic logic addr_match(input logic [6:0] rx_addr,
                                      input logic [6:0] base,
                                      input logic [6:0] dont_care);
    return ((rx_addr ^ base) & ~dont_care) == 7'd0;
  endfunction

endpackage

// File: rtl/i2c_rb_sync.sv
module i2c_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_q;
  logic [STAGES-1:0] sda_q;
  logic              scl_d;
  logic              sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2c_rb_regs.sv
module i2c_rb_regs
  import i2c_rb_pkg::*;
#(
  parameter int NUM_REGS = 16,
  localparam int PTR_W   = $clog2(NUM_REGS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [PTR_W-1:0]           wr_idx,
  input  logic [BYTE_W-1:0]          wr_data,
  input  logic [PTR_W-1:0]           rd_idx,
  output logic [BYTE_W-1:0]          rd_data,
  output logic [NUM_REGS*BYTE_W-1:0] regs_flat
);

  logic [BYTE_W-1:0] bank [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bank[g] <= '0;
      end else if (wr_en && wr_idx == PTR_W'(g)) begin
        bank[g] <= wr_data;
      end
    end
    assign regs_flat[g*BYTE_W +: BYTE_W] = bank[g];
  end

  assign rd_data = bank[rd_idx];

endmodule

// File: rtl/i2c_rb_engine.sv
module i2c_rb_engine
  import i2c_rb_pkg::*;
#(
  parameter int         NUM_REGS  = 16,
  parameter logic [6:0] ADDR_BASE = 7'h58,
  parameter logic [6:0] ADDR_DC   = 7'h04,
  localparam int        PTR_W     = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_oe,
  output logic              wr_en,
  output logic [PTR_W-1:0]  wr_idx,
  output logic [BYTE_W-1:0] wr_data,
  output logic [PTR_W-1:0]  ptr,
  output logic              ptr_adv,
  output logic              addr_done,
  output logic              addr_hit,
  output logic              rack_nack
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_REGS - 1);

  bus_state_t        state;
  bus_state_t        ack_next;
  logic [2:0]        cnt;
  logic              got;
  logic [BYTE_W-1:0] sh;
  logic              tx_last;
  logic              rx_state;

  function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PTR_W-1:0] ptr_from_byte(input logic [BYTE_W-1:0] b);
    logic [BYTE_W-1:0] m;
    m = b % BYTE_W'(NUM_REGS);
    return m[PTR_W-1:0];
  endfunction

  assign rx_state  = (state == ST_ADDR) || (state == ST_PTR) || (state == ST_WDATA);
  assign addr_done = (state == ST_ADDR) && got && scl_fall;
  assign addr_hit  = addr_match(sh[7:1], ADDR_BASE, ADDR_DC);
  assign wr_en     = (state == ST_WDATA) && got && scl_fall;
  assign wr_idx    = ptr;
  assign wr_data   = sh;
  assign tx_last   = (state == ST_RDATA) && scl_fall && (cnt == 3'd7);
  assign rack_nack = (state == ST_RACK) && scl_rise && sda_s;
  assign ptr_adv   = wr_en || tx_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      ack_next <= ST_IDLE;
      cnt      <= '0;
      got      <= 1'b0;
      sh       <= '0;
      ptr      <= '0;
      sda_oe   <= 1'b0;
    end else if (start_det) begin
      state  <= ST_ADDR;
      cnt    <= '0;
      got    <= 1'b0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      got    <= 1'b0;
      sda_oe <= 1'b0;
    end else if (rx_state) begin
      if (scl_rise && !got) begin
        sh <= {sh[6:0], sda_s};
        if (cnt == 3'd7) got <= 1'b1;
        else cnt <= cnt + 1'b1;
      end else if (scl_fall && got) begin
        got <= 1'b0;
        cnt <= '0;
        unique case (state)
          ST_ADDR: begin
            if (addr_hit) begin
              sda_oe   <= 1'b1;
              state    <= ST_ACK;
              ack_next <= sh[0] ? ST_RDATA : ST_PTR;
            end else begin
              state <= ST_SKIP;
            end
          end
          ST_PTR: begin
            ptr      <= ptr_from_byte(sh);
            sda_oe   <= 1'b1;
            state    <= ST_ACK;
            ack_next <= ST_WDATA;
          end
          default: begin
            ptr      <= ptr_step(ptr);
            sda_oe   <= 1'b1;
            state    <= ST_ACK;
            ack_next <= ST_WDATA;
          end
        endcase
      end
    end else begin
      unique case (state)
        ST_ACK: begin
          if (scl_fall) begin
            cnt <= '0;
            got <= 1'b0;
            if (ack_next == ST_RDATA) begin
              sh     <= rd_data;
              sda_oe <= ~rd_data[7];
              state  <= ST_RDATA;
            end else begin
              sda_oe <= 1'b0;
              state  <= ack_next;
            end
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (cnt == 3'd7) begin
              sda_oe <= 1'b0;
              ptr    <= ptr_step(ptr);
              got    <= 1'b0;
              state  <= ST_RACK;
            end else begin
              sda_oe <= ~sh[6];
              sh     <= {sh[6:0], 1'b0};
              cnt    <= cnt + 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            if (sda_s) state <= ST_SKIP;
            else got <= 1'b1;
          end else if (scl_fall && got) begin
            sh     <= rd_data;
            sda_oe <= ~rd_data[7];
            cnt    <= '0;
            got    <= 1'b0;
            state  <= ST_RDATA;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target
  import i2c_rb_pkg::*;
#(
  parameter int         NUM_REGS    = 16,
  parameter logic [6:0] ADDR_BASE   = 7'h58,
  parameter logic [6:0] ADDR_DC     = 7'h04,
  parameter int         SYNC_STAGES = 2,
  localparam int        PTR_W       = $clog2(NUM_REGS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       scl_i,
  input  logic                       sda_i,
  output logic                       sda_oe_o,
  output logic [NUM_REGS*BYTE_W-1:0] regs_o
);

  logic              scl_s;
  logic              sda_s;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_det;
  logic              stop_det;
  logic              wr_en;
  logic [PTR_W-1:0]  wr_idx;
  logic [BYTE_W-1:0] wr_data;
  logic [BYTE_W-1:0] rd_data;
  logic [PTR_W-1:0]  ptr;
  logic              ptr_adv;
  logic              addr_done;
  logic              addr_hit;
  logic              rack_nack;

  i2c_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_rb_engine #(
    .NUM_REGS  (NUM_REGS),
    .ADDR_BASE (ADDR_BASE),
    .ADDR_DC   (ADDR_DC)
  ) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rd_data   (rd_data),
    .sda_oe    (sda_oe_o),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .ptr       (ptr),
    .ptr_adv   (ptr_adv),
    .addr_done (addr_done),
    .addr_hit  (addr_hit),
    .rack_nack (rack_nack)
  );

  i2c_rb_regs #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .rd_idx    (ptr),
    .rd_data   (rd_data),
    .regs_flat (regs_o)
  );

endmodule

// File: rtl/i2c_rb_checker.sv
module i2c_rb_checker #(
  parameter int  NUM_REGS = 16,
  localparam int PTR_W    = $clog2(NUM_REGS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_s,
  input logic             sda_oe_o,
  input logic             start_det,
  input logic             stop_det,
  input logic             wr_en,
  input logic [PTR_W-1:0] ptr,
  input logic             ptr_adv,
  input logic             addr_done,
  input logic             addr_hit,
  input logic             rack_nack
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_REGS - 1);

  assert_reject_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    addr_done && !addr_hit |=> !sda_oe_o);

  assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_adv && ptr != LAST |=> ptr == $past(ptr) + 1'b1);

  assert_commit_at_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> sda_oe_o);

  assert_no_commit_after_cond_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start_det || stop_det |=> !wr_en);

  assert_ptr_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_adv && ptr == LAST |=> ptr == '0);

  assert_release_on_nack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rack_nack |=> !sda_oe_o);

  assert_oe_moves_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> !$past(scl_s));

endmodule

bind i2c_regbank_target i2c_rb_checker #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_s     (scl_s),
  .sda_oe_o  (sda_oe_o),
  .start_det (start_det),
  .stop_det  (stop_det),
  .wr_en     (wr_en),
  .ptr       (ptr),
  .ptr_adv   (ptr_adv),
  .addr_done (addr_done),
  .addr_hit  (addr_hit),
  .rack_nack (rack_nack)
);

// File: tb/i2c_regbank_target_bench.sv
`timescale 1ns/1ps
module i2c_regbank_target_bench;

  localparam int Q = 10;  // quarter SCL period in system clocks

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         scl = 1'b1;
  logic         host_sda = 1'b1;
  logic         sda_oe;
  logic [127:0] regs_o;
  wire          sda_bus = host_sda & ~sda_oe;

  int n_cmp = 0;
  int n_bad = 0;
  int oe_hi_moves = 0;
  int oe_seen = 0;
  logic oe_prev = 1'b0;
  logic [7:0] exp_reg [16];

  always #2.5 clk = ~clk;

  i2c_regbank_target u_i2c_regbank_target (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl),
    .sda_i    (sda_bus),
    .sda_oe_o (sda_oe),
    .regs_o   (regs_o)
  );

  always @(posedge clk) begin
    if (rst_n) begin
      if (sda_oe !== oe_prev && scl) oe_hi_moves++;
      if (sda_oe) oe_seen++;
    end
    oe_prev <= sda_oe;
  end

  function automatic logic [7:0] reg_at(input int idx);
    return regs_o[idx*8 +: 8];
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_all_regs(input string req);
    for (int i = 0; i < 16; i++) check(req, $sformatf("reg%0d", i), {24'd0, reg_at(i)}, {24'd0, exp_reg[i]});
  endtask

  task automatic wq(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    host_sda = 1'b1; wq(1);
    scl = 1'b1;      wq(1);
    host_sda = 1'b0; wq(1);
    scl = 1'b0;      wq(1);
  endtask

  task automatic bus_stop();
    host_sda = 1'b0; wq(1);
    scl = 1'b1;      wq(1);
    host_sda = 1'b1; wq(1);
  endtask

  task automatic send_bit(input logic b);
    host_sda = b; wq(1);
    scl = 1'b1;   wq(2);
    scl = 1'b0;   wq(1);
  endtask

  task automatic send_bits(input logic [7:0] v, input int n);
    for (int i = 7; i > 7 - n; i--) send_bit(v[i]);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    send_bits(v, 8);
    host_sda = 1'b1; wq(1);
    scl = 1'b1;      wq(1);
    ack = ~sda_bus;  wq(1);
    scl = 1'b0;      wq(1);
  endtask

  task automatic read_byte(input logic host_ack, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      host_sda = 1'b1; wq(1);
      scl = 1'b1;      wq(1);
      v[i] = sda_bus;  wq(1);
      scl = 1'b0;      wq(1);
    end
    send_bit(~host_ack);
  endtask

  task automatic t_reset();
    check("R10", "sda released", {31'd0, sda_oe}, 32'd0);
    check_all_regs("R10");
  endtask

  task automatic t_single_write();
    logic a;
    bus_start();
    send_byte(8'hB0, a); check("R1", "ack at 0x58", {31'd0, a}, 32'd1);
    send_byte(8'h05, a); check("R2", "ack pointer", {31'd0, a}, 32'd1);
    send_byte(8'hA5, a); check("R3", "ack data", {31'd0, a}, 32'd1);
    exp_reg[5] = 8'hA5;
    check("R12", "reg5 field", {24'd0, regs_o[47:40]}, 32'hA5);
    bus_stop();
    check_all_regs("R3");
  endtask

  task automatic t_alt_addr_write();
    logic a;
    bus_start();
    send_byte(8'hB8, a); check("R1", "ack at 0x5C", {31'd0, a}, 32'd1);
    send_byte(8'h12, a); check("R2", "ack pointer 0x12", {31'd0, a}, 32'd1);
    send_byte(8'h3C, a);
    exp_reg[2] = 8'h3C;
    bus_stop();
    check_all_regs("R2");
  endtask

  task automatic t_wrong_addr();
    logic a;
    bus_start();
    oe_seen = 0;
    send_byte(8'hB4, a); check("R1", "no ack at 0x5A", {31'd0, a}, 32'd0);
    send_byte(8'h02, a); check("R1", "no ack byte after miss", {31'd0, a}, 32'd0);
    send_byte(8'hEE, a); check("R1", "no ack data after miss", {31'd0, a}, 32'd0);
    check("R1", "sda never pulled", oe_seen, 32'd0);
    bus_stop();
    check_all_regs("R1");
  endtask

  task automatic t_burst_write();
    logic a;
    bus_start();
    send_byte(8'hB0, a);
    send_byte(8'h0E, a);
    send_byte(8'h11, a);
    check("R4", "reg14 at its ack", {24'd0, reg_at(14)}, 32'h11);
    check("R4", "reg15 still old", {24'd0, reg_at(15)}, 32'h00);
    send_byte(8'h22, a);
    check("R4", "reg15 at its ack", {24'd0, reg_at(15)}, 32'h22);
    send_byte(8'h33, a);
    check("R8", "write wraps to reg0", {24'd0, reg_at(0)}, 32'h33);
    send_byte(8'h44, a);
    check("R8", "reg1 after wrap", {24'd0, reg_at(1)}, 32'h44);
    exp_reg[14] = 8'h11; exp_reg[15] = 8'h22; exp_reg[0] = 8'h33; exp_reg[1] = 8'h44;
    bus_stop();
    check_all_regs("R8");
  endtask

  task automatic t_partial_stop();
    logic a;
    bus_start();
    send_byte(8'hB0, a);
    send_byte(8'h03, a);
    send_byte(8'h77, a);
    exp_reg[3] = 8'h77;
    send_bits(8'hFF, 4);
    bus_stop();
    check("R5", "reg4 after stop mid-byte", {24'd0, reg_at(4)}, 32'h00);
    check_all_regs("R5");
  endtask

  task automatic t_random_read();
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte(8'hB0, a);
    send_byte(8'h05, a);
    bus_start();
    send_byte(8'hB9, a); check("R6", "ack read address", {31'd0, a}, 32'd1);
    read_byte(1'b0, d);  check("R6", "read reg5", {24'd0, d}, 32'hA5);
    oe_seen = 0;
    for (int i = 0; i < 9; i++) send_bit(1'b1);
    check("R9", "released after nack", oe_seen, 32'd0);
    bus_stop();
  endtask

  task automatic t_seq_read();
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte(8'hB0, a);
    send_byte(8'h0E, a);
    bus_start();
    send_byte(8'hB1, a);
    read_byte(1'b1, d); check("R7", "read reg14", {24'd0, d}, 32'h11);
    read_byte(1'b1, d); check("R7", "read reg15", {24'd0, d}, 32'h22);
    read_byte(1'b1, d); check("R8", "read wraps to reg0", {24'd0, d}, 32'h33);
    read_byte(1'b0, d); check("R7", "read reg1", {24'd0, d}, 32'h44);
    bus_stop();
  endtask

  task automatic t_partial_rstart();
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte(8'hB0, a);
    send_byte(8'h06, a);
    send_byte(8'h66, a);
    exp_reg[6] = 8'h66;
    send_bits(8'h00, 5);
    bus_start();
    check("R5", "reg7 after restart mid-byte", {24'd0, reg_at(7)}, 32'h00);
    send_byte(8'hB0, a);
    send_byte(8'h06, a);
    bus_start();
    send_byte(8'hB1, a);
    read_byte(1'b0, d); check("R6", "read reg6 after restart", {24'd0, d}, 32'h66);
    bus_stop();
    check_all_regs("R5");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) exp_reg[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_single_write();
    t_alt_addr_write();
    t_wrong_addr();
    t_burst_write();
    t_partial_stop();
    t_random_read();
    t_seq_read();
    t_partial_rstart();
    check("R11", "oe changes with SCL high", oe_hi_moves, 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule